// File: doc/BRIEF.md
# I2C Channel-Select Slave Controller

This block is the digital control side of a four-way bus switch. It sits on a two-wire I2C bus as a slave with one 8-bit control register. A master writes the register to choose which downstream channels are connected, in any combination. It reads the register back to see the connected channels together with the state of one active-low interrupt line per channel. The four enable outputs are meant to drive the pass gates of the switch.

SCL and SDA are sampled on the system clock through two-flop synchronizers. START, STOP and clock edges are found from the synchronized values. A written selection is only staged during the transfer. It moves to the enable outputs when the STOP arrives, so the downstream lines are connected while the bus is idle. The SDA output is an open-drain pull request: 1 means the pad drives SDA low.

Top module: `chsel_i2c_slave`

## Requirements
- R1: The slave responds to the 7-bit address {1,1,1,0,0,addr_pins_i[1],addr_pins_i[0]}, sent MSB first and followed by the R/W bit (1 = read, 0 = write). On any other address it never pulls SDA low, and it ignores every following byte until the next START or STOP.
- R2: Bit i (for i = 0..3) of a written data byte enables channel i on chan_en_o[i]. Any combination of channels, including none or all, may be enabled.
- R3: A written selection reaches chan_en_o only when a STOP is detected. Until then chan_en_o keeps its previous value.
- R4: When a write carries several data bytes, the selection committed at STOP is the low nibble of the last byte.
- R5: A read returns one byte, MSB first. Bits 7..4 are 1 for each of channels 3..0 whose irq_ni line is low, sampled when the byte is loaded. Bits 3..0 are the currently committed enables.
- R6: After a matching address, and after each written data byte, the slave pulls SDA low for the ninth clock. On a read it releases SDA after the eighth data bit, and a NACK from the master ends the read.
- R7: While rst_ni is low, chan_en_o is 0 and SDA is released. After reset the bus logic is idle with nothing staged.
- R8: A repeated START restarts address reception and discards any staged selection that has not yet been committed.
- R9: Bits 7..4 of a written byte do not affect the enables or the value read back.
- R10: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Data bits are sampled on the rising edge of SCL, and the slave changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = drive SDA low (open drain) |
| addr_pins_i | input | 2 | Strapped low address bits |
| irq_ni | input | 4 | Active-low interrupt line per channel |
| chan_en_o | output | 4 | Channel enables, bit i = channel i |

## Verification
The hardest case to reach from the ports is a selection that has been acknowledged but not committed, and then gets thrown away. This needs a write byte followed by a repeated START instead of a STOP. The bench builds it directly by sending a data byte, issuing a repeated START into a read, and checking that the read and the final enables both still show the old selection. Enables are also sampled between the last ACK and the STOP of every write. Random transactions mix good and single-bit-corrupted addresses, multi-byte writes and reads under random interrupt patterns. This exercises the ignore path and last-byte-wins together.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int BYTE_W = 8;
  localparam int CH_N   = BYTE_W / 2;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_EVAL, ST_ADDR_ACK,
    ST_WDATA, ST_WEVAL, ST_WACK,
    ST_RDATA, ST_RACK, ST_RNEXT, ST_IGNORE
  } bus_state_e;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
endmodule

// File: rtl/chsel_bus_events.sv
module chsel_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end

  assign start_o = scl_q & scl_s_i & sda_q & ~sda_s_i;
  assign stop_o  = scl_q & scl_s_i & ~sda_q & sda_s_i;
  assign rise_o  = ~scl_q & scl_s_i;
  assign fall_o  = scl_q & ~scl_s_i;

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, rise_o, fall_o})); // R10
endmodule

// File: rtl/chsel_chan_reg.sv
module chsel_chan_reg #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stage_i,
  input  logic [N-1:0] stage_data_i,
  input  logic         drop_i,
  input  logic         commit_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] pend_q;
  logic         pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      en_o       <= '0;
    end else if (commit_i) begin
      if (pend_vld_q) en_o <= pend_q;
      pend_vld_q <= 1'b0;
    end else if (drop_i) begin
      pend_vld_q <= 1'b0;
    end else if (stage_i) begin
      pend_q     <= stage_data_i;  // later bytes overwrite earlier ones
      pend_vld_q <= 1'b1;
    end

  AST_EN_ONLY_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_o) |-> $past(commit_i)); // R3
  AST_DROP_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> $stable(en_o)); // R8
endmodule

// File: rtl/chsel_i2c_slave.sv
module chsel_i2c_slave
  import chsel_pkg::*;
#(
  parameter logic [4:0] ADDR_FIXED = 5'b11100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull_o,
  input  logic [1:0]      addr_pins_i,
  input  logic [CH_N-1:0] irq_ni,
  output logic [CH_N-1:0] chan_en_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [1:0]  sync_q;
  logic        scl_s, sda_s;
  logic        ev_start, ev_stop, ev_rise, ev_fall;
  bus_state_e  state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, rd_byte;
  logic        rw_q, addr_hit, stage;

  chsel_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(sync_q));
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  chsel_bus_events u_events (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_o(ev_start), .stop_o(ev_stop), .rise_o(ev_rise), .fall_o(ev_fall));

  assign addr_hit = (rx_q[BYTE_W-1:1] == {ADDR_FIXED, addr_pins_i});
  assign rd_byte  = {~irq_ni, chan_en_o};
  assign stage    = (state_q == ST_WEVAL) && ev_fall;

  chsel_chan_reg #(.N(CH_N)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stage_i(stage), .stage_data_i(rx_q[CH_N-1:0]),
    .drop_i(ev_start), .commit_i(ev_stop), .en_o(chan_en_o));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (ev_start) begin
      state_q    <= ST_ADDR;
      cnt_q      <= '0;
      sda_pull_o <= 1'b0;
    end else if (ev_stop) begin
      state_q    <= ST_IDLE;
      sda_pull_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: if (ev_rise) begin
          rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT)
            state_q <= (state_q == ST_ADDR) ? ST_ADDR_EVAL : ST_WEVAL;
        end
        ST_ADDR_EVAL: if (ev_fall) begin
          if (addr_hit) begin
            sda_pull_o <= 1'b1;
            rw_q       <= rx_q[0];
            state_q    <= ST_ADDR_ACK;
          end else begin
            state_q    <= ST_IGNORE;
          end
        end
        ST_ADDR_ACK, ST_RNEXT: if (ev_fall) begin
          cnt_q <= '0;
          if (rw_q) begin
            tx_q       <= rd_byte;
            sda_pull_o <= ~rd_byte[BYTE_W-1];
            state_q    <= ST_RDATA;
          end else begin
            sda_pull_o <= 1'b0;
            state_q    <= ST_WDATA;
          end
        end
        ST_WEVAL: if (ev_fall) begin
          sda_pull_o <= 1'b1;
          state_q    <= ST_WACK;
        end
        ST_WACK: if (ev_fall) begin
          sda_pull_o <= 1'b0;
          cnt_q      <= '0;
          state_q    <= ST_WDATA;
        end
        ST_RDATA: if (ev_fall) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            sda_pull_o <= 1'b0;
            state_q    <= ST_RACK;
          end else begin
            tx_q       <= {tx_q[BYTE_W-2:0], 1'b0};
            sda_pull_o <= ~tx_q[BYTE_W-2];
          end
        end
        ST_RACK: if (ev_rise) state_q <= sda_s ? ST_IGNORE : ST_RNEXT;
        default: ;
      endcase
    end

  AST_IGNORE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !sda_pull_o); // R1
  AST_ACK_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_rise && (state_q == ST_ADDR_ACK || state_q == ST_WACK)) |-> sda_pull_o); // R6
  AST_START_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_start |=> (!sda_pull_o && state_q == ST_ADDR)); // R8
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !$past(scl_s)); // R10
endmodule

// File: tb/chsel_i2c_slave_bench.sv
module chsel_i2c_slave_bench;
  localparam int Q = 10;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] pins = 2'b00;
  logic [3:0] irq_n = 4'hF;
  logic sda_pull;
  logic [3:0] chan_en;
  logic sda_line;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  logic [3:0] exp_en = 4'h0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  chsel_i2c_slave u_chsel_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .addr_pins_i(pins), .irq_ni(irq_n), .chan_en_o(chan_en));

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      total++; bad++;
      $display("FAIL watchdog all-reqs actual=%0d expected<%0d", cycles, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [6:0] dev_addr(input logic [1:0] p);
    return {5'b11100, p};
  endfunction
  function automatic logic [7:0] read_model(input logic [3:0] irq, input logic [3:0] en);
    return {~irq, en};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start; sda_m = 1; scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q); endtask
  task automatic bus_rstart; sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q); endtask
  task automatic bus_stop; sda_m = 0; w(Q); scl_m = 1; w(Q); sda_m = 1; w(Q); endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; w(Q); scl_m = 1; w(Q); seen = sda_line; w(Q); scl_m = 0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(nack, s);
  endtask

  initial begin
    logic ack;
    logic [7:0] rd;
    void'($urandom(32'd2024));
    w(5);
    chk("R7 reset en", {4'h0, chan_en}, 8'h00);
    chk("R7 reset sda", {7'h0, sda_pull}, 8'h00);
    rst_n = 1; w(5);

    // directed write
    pins = 2'b10;
    bus_start; send_byte({dev_addr(pins), 1'b0}, ack);
    chk("R1 addr ack", {7'h0, ack}, 8'h01);
    send_byte(8'h06, ack);
    chk("R6 data ack", {7'h0, ack}, 8'h01);
    chk("R3 before stop", {4'h0, chan_en}, 8'h00);
    bus_stop; exp_en = 4'h6;
    chk("R2 after stop", {4'h0, chan_en}, 8'h06);

    // directed read
    irq_n = 4'b0110;
    bus_start; send_byte({dev_addr(pins), 1'b1}, ack);
    chk("R6 read addr ack", {7'h0, ack}, 8'h01);
    read_byte(1'b1, rd); bus_stop;
    chk("R5 read byte", rd, read_model(irq_n, exp_en));

    // mismatch
    bus_start; send_byte({dev_addr(~pins), 1'b0}, ack);
    chk("R1 mismatch no ack", {7'h0, ack}, 8'h00);
    send_byte(8'h0F, ack);
    chk("R1 ignored data", {7'h0, ack}, 8'h00);
    bus_stop;
    chk("R1 en unchanged", {4'h0, chan_en}, {4'h0, exp_en});

    // multi-byte, upper nibble ignored
    bus_start; send_byte({dev_addr(pins), 1'b0}, ack);
    send_byte(8'h03, ack); send_byte(8'h0C, ack); send_byte(8'hF5, ack);
    chk("R3 multi before stop", {4'h0, chan_en}, {4'h0, exp_en});
    bus_stop; exp_en = 4'h5;
    chk("R4 last byte wins", {4'h0, chan_en}, 8'h05);
    irq_n = 4'hF;
    bus_start; send_byte({dev_addr(pins), 1'b1}, ack); read_byte(1'b1, rd); bus_stop;
    chk("R9 upper bits ignored", rd, 8'h05);

    // repeated start discards staged selection
    bus_start; send_byte({dev_addr(pins), 1'b0}, ack); send_byte(8'h0A, ack);
    bus_rstart; send_byte({dev_addr(pins), 1'b1}, ack);
    chk("R8 rstart addr ack", {7'h0, ack}, 8'h01);
    read_byte(1'b1, rd);
    chk("R8 read old en", rd, read_model(irq_n, exp_en));
    bus_stop;
    chk("R8 staged dropped", {4'h0, chan_en}, {4'h0, exp_en});

    // random traffic
    for (int it = 0; it < 40; it++) begin
      logic good;
      logic [6:0] a7;
      logic [3:0] nxt;
      int op, nb;
      pins = 2'($urandom);
      good = ($urandom % 4) != 0;
      a7 = good ? dev_addr(pins) : dev_addr(pins) ^ (7'd1 << ($urandom % 7));
      op = $urandom % 2;
      nxt = exp_en;
      if (op == 0) begin
        bus_start; send_byte({a7, 1'b0}, ack);
        chk("R1 rand addr ack", {7'h0, ack}, {7'h0, good});
        nb = 1 + $urandom % 3;
        for (int j = 0; j < nb; j++) begin
          logic [7:0] d;
          d = 8'($urandom);
          send_byte(d, ack);
          chk("R6 rand data ack", {7'h0, ack}, {7'h0, good});
          if (good) nxt = d[3:0];
        end
        chk("R3 rand before stop", {4'h0, chan_en}, {4'h0, exp_en});
        bus_stop; exp_en = nxt;
        chk("R4 rand after stop", {4'h0, chan_en}, {4'h0, exp_en});
      end else begin
        irq_n = 4'($urandom);
        bus_start; send_byte({a7, 1'b1}, ack);
        chk("R1 rand read ack", {7'h0, ack}, {7'h0, good});
        if (good) begin
          read_byte(1'b1, rd);
          chk("R5 rand read", rd, read_model(irq_n, exp_en));
        end
        bus_stop;
      end
    end

    // reset in the middle of a write
    if (exp_en == 4'h0) begin
      bus_start; send_byte({dev_addr(pins), 1'b0}, ack); send_byte(8'h09, ack); bus_stop;
    end
    bus_start; send_byte({dev_addr(pins), 1'b0}, ack); send_byte(8'h0F, ack);
    rst_n = 0; w(3);
    chk("R7 async clear", {4'h0, chan_en}, 8'h00);
    scl_m = 1; sda_m = 1; w(5); rst_n = 1; w(5);
    chk("R7 idle after reset", {7'h0, sda_pull}, 8'h00);
    bus_start; send_byte({dev_addr(pins), 1'b1}, ack); read_byte(1'b1, rd); bus_stop;
    chk("R7 read after reset", rd[3:0], 4'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule